// File: doc/BRIEF.md
# Half-Bridge Gate Command Decoder

This block takes high-side and low-side command bits for each phase of a bridge and produces registered high-side and low-side gate enables. A polarity select picks how the low command is read. In the plain scheme a set low bit asks for the low-side switch. In the inverted scheme a cleared low bit asks for it, so one signal wired to both command bits of a phase selects high (1) or low (0). Any combination that is not valid in the selected scheme switches both gates off. The phases are decoded and timed independently.

Each phase runs a small state machine with four states. ST_IDLE has both gates off and runs a dead-time counter. ST_HIGH and ST_LOW each drive one gate. ST_FAULT holds both gates off. The transitions are as follows. *idle-to-high* and *idle-to-low* are taken only once both gates have been off for DEAD_CYCLES clocks. *drive-to-idle* happens on the next clock whenever the decoded target differs from the gate being driven. *any-to-fault* happens whenever the fault input is sampled high. *fault-to-idle* happens on the first clock with fault low, and it restarts the dead-time count. Command bits and the polarity select pass through a two-stage synchronizer. The fault input is sampled directly, so that it acts within one clock. A build parameter FIXED_INVERT ties the polarity to the inverted scheme and ignores the select pin.

Top module: `hb_gate_decoder`

## Requirements
- R1: With `mode_inv`=0 and FIXED_INVERT=0, the {hi,lo} commands map as follows: {0,0} gives both gates off, {0,1} gives only the low gate, and {1,0} gives only the high gate.
- R2: With `mode_inv`=0, the command {1,1} is invalid, and both gates of that phase are held off.
- R3: With `mode_inv`=1, the {hi,lo} commands map as follows: {0,0} gives only the low gate, {0,1} gives both off, {1,0} is invalid and gives both off, and {1,1} gives only the high gate.
- R4: With `mode_inv`=1 and the same value on both command bits of a phase, 0 selects the low gate and 1 selects the high gate. Changing between them passes through the dead time.
- R5: With FIXED_INVERT=1, the mapping of R3 applies whatever the value of `mode_inv`.
- R6: A gate turns on only after both gates of its phase have been off for at least DEAD_CYCLES consecutive clocks. This includes the period after reset.
- R7: A decoded target that is not the gate currently driven turns that gate off at the next clock edge, with no dead-time delay.
- R8: While reset is asserted, all gate outputs are low. A command change applied before a rising edge can first reach the outputs at the third rising edge (two synchronizer stages plus the output register).
- R9: A high `fault` sampled at a rising edge drives every gate low at that edge, and they stay low while it remains high.
- R10: After `fault` is released, both gates of every phase stay off for at least DEAD_CYCLES clocks, counted from the first edge at which fault is sampled low.
- R11: `gate_hi[p]` and `gate_lo[p]` are never both high in the same cycle.
- R12: Each phase is decoded and timed from its own command bits only. Activity on one phase does not change the outputs of another phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_inv | input | 1 | Polarity select: 0 plain, 1 inverted low command (ignored when FIXED_INVERT=1) |
| fault | input | 1 | Synchronous fault; high forces all gates off |
| cmd_hi | input | NUM_PHASES | High-side command bit per phase |
| cmd_lo | input | NUM_PHASES | Low-side command bit per phase |
| gate_hi | output | NUM_PHASES | Registered high-side gate enable per phase |
| gate_lo | output | NUM_PHASES | Registered low-side gate enable per phase |

## Verification
The hardest cases to reach are a command that reverses while a phase is still counting its dead time, and a fault that arrives or clears part way through that count. In both cases the turn-on must wait for a fresh, full interval. The stimulus therefore holds command patterns for random lengths, many of them shorter than DEAD_CYCLES. It mixes in short fault pulses and polarity flips, so that phases are often caught mid-count. A second instance with FIXED_INVERT=1 and a short dead time receives the same inputs and is checked against its own reference model.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [1:0] {
        TGT_OFF  = 2'd0,
        TGT_HIGH = 2'd1,
        TGT_LOW  = 2'd2
    } hbd_target_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2,
        ST_FAULT = 2'd3
    } hbd_state_e;

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/hbd_decode.sv
module hbd_decode
    import hbd_pkg::*;
(
    input  logic        inv_i,
    input  logic        hi_i,
    input  logic        lo_i,
    output hbd_target_e tgt_o
);
    logic lo_active;

    always_comb begin
        // Under the inverted scheme the low command is active-low.
        lo_active = lo_i ^ inv_i;
        unique case ({hi_i, lo_active})
            2'b10:   tgt_o = TGT_HIGH;
            2'b01:   tgt_o = TGT_LOW;
            default: tgt_o = TGT_OFF;   // both idle or invalid pair
        endcase
    end
endmodule

// File: rtl/hbd_phase.sv
module hbd_phase
    import hbd_pkg::*;
#(
    parameter int DEAD_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fault_i,
    input  hbd_target_e tgt_i,
    output logic        gate_hi_o,
    output logic        gate_lo_o
);
    localparam int CW = $clog2(DEAD_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYCLES - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEAD_CYCLES);

    hbd_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          gate_hi_q, gate_lo_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fault_i) begin
            state_d = ST_FAULT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tgt_i != TGT_OFF && cnt_q == CNT_LAST) begin
                        state_d = (tgt_i == TGT_HIGH) ? ST_HIGH : ST_LOW;
                    end else if (cnt_q != CNT_LAST) begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_HIGH: begin
                    if (tgt_i != TGT_HIGH) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end
                ST_LOW: begin
                    if (tgt_i != TGT_LOW) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end
                ST_FAULT: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_hi_q <= 1'b0;
            gate_lo_q <= 1'b0;
        end else begin
            gate_hi_q <= (state_d == ST_HIGH);
            gate_lo_q <= (state_d == ST_LOW);
        end
    end

    assign gate_hi_o = gate_hi_q;
    assign gate_lo_o = gate_lo_q;

    // Checker: length of the current run of both-off cycles, saturating.
    logic [CW-1:0] chk_off_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_off_q <= '0;
        end else if (gate_hi_q || gate_lo_q) begin
            chk_off_q <= '0;
        end else if (chk_off_q != CNT_FULL) begin
            chk_off_q <= chk_off_q + CW'(1);
        end
    end

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_q && gate_lo_q));

    assert_dead_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi_q) || $rose(gate_lo_q)) |-> (chk_off_q >= CNT_FULL));

    assert_off_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_i == TGT_OFF) |=> (!gate_hi_q && !gate_lo_q));

    assert_release_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_i && $past(fault_i)) |=> (!gate_hi_q && !gate_lo_q));
endmodule

// File: rtl/hb_gate_decoder.sv
module hb_gate_decoder
    import hbd_pkg::*;
#(
    parameter int NUM_PHASES   = 3,
    parameter int DEAD_CYCLES  = 8,
    parameter bit FIXED_INVERT = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_inv,
    input  logic                  fault,
    input  logic [NUM_PHASES-1:0] cmd_hi,
    input  logic [NUM_PHASES-1:0] cmd_lo,
    output logic [NUM_PHASES-1:0] gate_hi,
    output logic [NUM_PHASES-1:0] gate_lo
);
    localparam int CMD_W = 2 * NUM_PHASES;

    logic [CMD_W-1:0]      cmd_sync;
    logic [NUM_PHASES-1:0] hi_s, lo_s;
    logic                  inv_eff;

    hbd_sync #(.WIDTH(CMD_W)) u_cmd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cmd_hi, cmd_lo}),
        .q_o   (cmd_sync)
    );

    assign hi_s = cmd_sync[CMD_W-1:NUM_PHASES];
    assign lo_s = cmd_sync[NUM_PHASES-1:0];

    generate
        if (FIXED_INVERT) begin : g_fixed_inv
            assign inv_eff = 1'b1;
        end else begin : g_pin_mode
            hbd_sync #(.WIDTH(1)) u_mode_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (mode_inv),
                .q_o   (inv_eff)
            );
        end
    endgenerate

    generate
        for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
            hbd_target_e tgt;

            hbd_decode u_decode (
                .inv_i (inv_eff),
                .hi_i  (hi_s[p]),
                .lo_i  (lo_s[p]),
                .tgt_o (tgt)
            );

            hbd_phase #(.DEAD_CYCLES(DEAD_CYCLES)) u_phase (
                .clk       (clk),
                .rst_n     (rst_n),
                .fault_i   (fault),
                .tgt_i     (tgt),
                .gate_hi_o (gate_hi[p]),
                .gate_lo_o (gate_lo[p])
            );
        end
    endgenerate

    assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/hb_gate_decoder_bench.sv
`timescale 1ns/1ps
module hb_gate_decoder_bench;
    localparam int NP = 3;
    localparam int D0 = 8;
    localparam int D1 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_inv = 1'b0;
    logic fault = 1'b0;
    logic [NP-1:0] cmd_hi = '0;
    logic [NP-1:0] cmd_lo = '0;
    logic [NP-1:0] gh0, gl0, gh1, gl1;

    int errors = 0;
    int checks = 0;
    string cur_req = "R8";

    always #2 clk = ~clk;   // 250 MHz

    hb_gate_decoder #(.NUM_PHASES(NP), .DEAD_CYCLES(D0), .FIXED_INVERT(1'b0)) u_hb_gate_decoder (
        .clk(clk), .rst_n(rst_n), .mode_inv(mode_inv), .fault(fault),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .gate_hi(gh0), .gate_lo(gl0)
    );

    hb_gate_decoder #(.NUM_PHASES(NP), .DEAD_CYCLES(D1), .FIXED_INVERT(1'b1)) u_fixed (
        .clk(clk), .rst_n(rst_n), .mode_inv(mode_inv), .fault(fault),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .gate_hi(gh1), .gate_lo(gl1)
    );

    // Reference model: 0 = both off, 1 = high gate, 2 = low gate
    int m_out   [2][NP];
    int m_quiet [2][NP];
    bit m_held  [2][NP];
    logic [NP-1:0] p1_hi, p1_lo, p2_hi, p2_lo;
    logic p1_m, p2_m;

    function automatic int wanted(bit inv, bit h, bit l);
        case ({inv, h, l})
            3'b000: return 0;
            3'b001: return 2;
            3'b010: return 1;
            3'b011: return 0;
            3'b100: return 2;
            3'b101: return 0;
            3'b110: return 0;
            default: return 1;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++)
                for (int p = 0; p < NP; p++) begin
                    m_out[d][p] = 0; m_quiet[d][p] = 0; m_held[d][p] = 0;
                end
            p1_hi = '0; p1_lo = '0; p2_hi = '0; p2_lo = '0; p1_m = 0; p2_m = 0;
        end else begin
            for (int d = 0; d < 2; d++) begin
                int dead;
                dead = (d == 0) ? D0 : D1;
                for (int p = 0; p < NP; p++) begin
                    int w;
                    w = wanted((d == 1) ? 1'b1 : p2_m, p2_hi[p], p2_lo[p]);
                    if (fault) begin
                        m_out[d][p] = 0; m_quiet[d][p] = 0; m_held[d][p] = 1;
                    end else if (m_held[d][p]) begin
                        m_held[d][p] = 0; m_quiet[d][p] = 0;
                    end else if (m_out[d][p] != 0) begin
                        if (w != m_out[d][p]) begin
                            m_out[d][p] = 0; m_quiet[d][p] = 0;
                        end
                    end else begin
                        m_quiet[d][p]++;
                        if (w != 0 && m_quiet[d][p] >= dead) m_out[d][p] = w;
                    end
                end
            end
            p2_hi = p1_hi; p2_lo = p1_lo; p2_m = p1_m;
            p1_hi = cmd_hi; p1_lo = cmd_lo; p1_m = mode_inv;
        end
        for (int p = 0; p < NP; p++) begin
            chk(cur_req, $sformatf("main phase %0d", p), {gh0[p], gl0[p]},
                {m_out[0][p] == 1, m_out[0][p] == 2});
            chk("R5", $sformatf("fixed phase %0d", p), {gh1[p], gl1[p]},
                {m_out[1][p] == 1, m_out[1][p] == 2});
        end
        chk("R11", "overlap", {|(gh0 & gl0), |(gh1 & gl1)}, 2'b00);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_cmd(logic [NP-1:0] h, logic [NP-1:0] l, int n);
        cmd_hi = h; cmd_lo = l;
        cyc(n);
    endtask

    initial begin
        cyc(3);
        cur_req = "R8";
        rst_n = 1'b1;
        cur_req = "R6";
        set_cmd(3'b001, 3'b010, 20);
        cur_req = "R1";
        set_cmd(3'b000, 3'b000, 15);
        set_cmd(3'b000, 3'b001, 15);
        set_cmd(3'b001, 3'b000, 15);
        cur_req = "R7";
        set_cmd(3'b001, 3'b001, 4);
        set_cmd(3'b000, 3'b001, 15);
        cur_req = "R2";
        set_cmd(3'b011, 3'b011, 15);
        cur_req = "R3";
        mode_inv = 1'b1;
        set_cmd(3'b000, 3'b000, 15);
        set_cmd(3'b000, 3'b111, 15);
        set_cmd(3'b111, 3'b000, 15);
        set_cmd(3'b111, 3'b111, 15);
        cur_req = "R4";
        for (int i = 0; i < 12; i++) begin
            logic [NP-1:0] v;
            v = (i % 2 == 0) ? 3'b101 : 3'b010;
            set_cmd(v, v, (i < 6) ? 12 : 3 + i);
        end
        cur_req = "R9";
        set_cmd(3'b111, 3'b111, 15);
        fault = 1'b1; cyc(5);
        cur_req = "R10";
        fault = 1'b0; cyc(20);
        set_cmd(3'b000, 3'b000, 4);
        fault = 1'b1; cyc(1);
        fault = 1'b0; cyc(20);
        cur_req = "R12";
        for (int i = 0; i < 3000; i++) begin
            cmd_hi   = NP'($urandom);
            cmd_lo   = NP'($urandom);
            if ($urandom_range(0, 15) == 0) mode_inv = ~mode_inv;
            fault    = ($urandom_range(0, 40) == 0);
            cyc($urandom_range(1, 12));
        end
        fault = 1'b0;
        cyc(20);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule